// File: doc/BRIEF.md
# Per-Channel Hit and Energy Trigger Front-End

This block takes one sample from each of 16 ADC channels every 4 ns and turns the set into one level-1 trigger word. For each channel it removes a programmable pedestal. A result below zero becomes zero. It then compares the result with that channel's own threshold. Each channel that passes sets one bit in a 16-bit hit pattern and adds its energy to the board sum. A channel that does not pass adds nothing, so low-level noise never reaches the sum.

The sum comes out of a registered adder tree. It is 16 bits wide and saturates at its maximum. A coincidence flag is set when enough of the enabled hit bits are present at once. The configuration inputs are plain levels and are expected to change only while no words are in flight.

Samples enter through a valid/ready stream and words leave through another one. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. An output word is taken on an edge where `out_valid` and `out_ready` are both high. While the output holds a word that has not been taken, the whole pipeline freezes. `in_ready` is low during that time, and the held word does not change. With `out_ready` held high the block accepts one sample set on every clock.

Top module: `hit_energy_frontend`

## Requirements
- R1: Each channel's net energy is its sample minus its pedestal when the sample is larger than the pedestal, and zero otherwise. Channel i uses bits [i*14 +: 14] of the samples, pedestals and thresholds inputs.
- R2: Bit i of `out_hits` is 1 exactly when channel i's net energy is strictly greater than its threshold. A net energy equal to the threshold gives 0.
- R3: `out_sum` is the sum of the net energies of the channels whose hit bit is 1. Channels without a hit contribute zero, and a word with no hits has a sum of zero.
- R4: When the true sum exceeds 65535, `out_sum` is 65535 and does not wrap.
- R5: `out_coinc` is 1 exactly when the number of ones in `out_hits & coinc_mask` is at least `min_mult`. A `min_mult` of 0 therefore always gives 1.
- R6: With `out_ready` high, the word for a sample set accepted at clock edge k appears with `out_valid` high after edge k+3, which is the fourth edge counted from acceptance. A continuous input stream then gives one output word per clock.
- R7: While `out_valid` is high and `out_ready` is low, the output word stays unchanged and `in_ready` is low. Words leave in the order they were accepted, with none lost and none repeated.
- R8: During reset and after it, `out_valid` is 0 until a sample set has been accepted. `in_ready` is 1 while the pipeline is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample set per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample set is presented |
| in_ready | output | 1 | The block takes the presented set at this edge |
| in_samples | input | 224 | 16 unsigned 14-bit samples, channel i at [i*14 +: 14] |
| pedestals | input | 224 | Per-channel pedestal, same packing |
| thresholds | input | 224 | Per-channel hit threshold, same packing |
| coinc_mask | input | 16 | Hit bits that take part in the coincidence |
| min_mult | input | 5 | Minimum count of enabled hits for the coincidence |
| out_valid | output | 1 | A trigger word is present |
| out_ready | input | 1 | The downstream side takes the word at this edge |
| out_hits | output | 16 | Hit pattern, bit i for channel i |
| out_sum | output | 16 | Saturated sum of the energies of the hit channels |
| out_coinc | output | 1 | Coincidence flag |

## Verification
Two events can fall in the same cycle: the output side stalls a finished word, and a new sample set arrives at the input. Both must be handled without the word in the last stage moving or a new set being taken. The bench provokes this by streaming samples while `out_ready` drops at pseudo-random points. Every word that leaves is matched in order against a queue of hit patterns, sums and flags computed arithmetically. A separate test holds one word for several cycles and checks that it stays stable and that `in_ready` stays low. Saturation and suppression also meet in one word. Their sweeps check both the clamped sum and the hit pattern of the same output word.

// File: rtl/hef_pkg.sv
package hef_pkg;
  localparam int HEF_NCH   = 16;
  localparam int HEF_SW    = 14;
  localparam int HEF_OW    = 16;
  localparam int HEF_GROUP = 4;
endpackage

// File: rtl/hef_channel.sv
module hef_channel #(
  parameter int SW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [SW-1:0] sample,
  input  logic [SW-1:0] pedestal,
  input  logic [SW-1:0] threshold,
  output logic          hit_q,
  output logic [SW-1:0] energy_q
);
  logic [SW-1:0] net;
  logic          over;

  always_comb begin
    net  = (sample > pedestal) ? (sample - pedestal) : '0;
    over = (net > threshold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      energy_q <= '0;
    end else if (adv) begin
      hit_q    <= over;
      energy_q <= over ? net : '0;
    end
  end

  AST_HIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> (energy_q != '0)); // R2
endmodule

// File: rtl/hef_sum_tree.sv
module hef_sum_tree #(
  parameter int N     = 16,
  parameter int IW    = 14,
  parameter int OW    = 16,
  parameter int GROUP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [N*IW-1:0] terms,
  output logic [OW-1:0]   sum_q
);
  localparam int NG = N / GROUP;
  localparam int GW = IW + $clog2(GROUP);
  localparam int TW = IW + $clog2(N);

  logic [NG*GW-1:0] part_flat;
  logic [TW-1:0]    total_d;
  logic [TW-1:0]    total_q;

  genvar g;
  generate
    for (g = 0; g < NG; g++) begin : g_grp
      logic [GW-1:0] psum_d;
      logic [GW-1:0] psum_q;
      always_comb begin
        psum_d = '0;
        for (int k = 0; k < GROUP; k++)
          psum_d = psum_d + GW'(terms[(g*GROUP+k)*IW +: IW]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   psum_q <= '0;
        else if (adv) psum_q <= psum_d;
      end
      assign part_flat[g*GW +: GW] = psum_q;
    end
  endgenerate

  always_comb begin
    total_d = '0;
    for (int i = 0; i < NG; i++)
      total_d = total_d + TW'(part_flat[i*GW +: GW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   total_q <= '0;
    else if (adv) total_q <= total_d;
  end

  generate
    if (TW > OW) begin : g_sat
      localparam logic [TW-1:0] MAXV = TW'({OW{1'b1}});
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum_q <= '0;
        else if (adv) sum_q <= (total_q > MAXV) ? MAXV[OW-1:0] : total_q[OW-1:0];
      end
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(adv) && ($past(total_q) > MAXV)) |-> (sum_q == MAXV[OW-1:0])); // R4
    end else begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum_q <= '0;
        else if (adv) sum_q <= OW'(total_q);
      end
    end
  endgenerate
endmodule

// File: rtl/hef_coinc.sv
module hef_coinc #(
  parameter int N  = 16,
  parameter int MW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [N-1:0]  hits,
  input  logic [N-1:0]  mask,
  input  logic [MW-1:0] min_mult,
  output logic          flag_q
);
  logic [N-1:0]  masked;
  logic [MW-1:0] cnt_d;
  logic [MW-1:0] cnt_q;

  always_comb begin
    masked = hits & mask;
    cnt_d  = '0;
    for (int i = 0; i < N; i++)
      cnt_d = cnt_d + MW'(masked[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (adv) begin
      cnt_q  <= cnt_d;
      flag_q <= (cnt_q >= min_mult);
    end
  end
endmodule

// File: rtl/hit_energy_frontend.sv
module hit_energy_frontend #(
  parameter int NCH   = hef_pkg::HEF_NCH,
  parameter int SW    = hef_pkg::HEF_SW,
  parameter int OW    = hef_pkg::HEF_OW,
  parameter int GROUP = hef_pkg::HEF_GROUP,
  localparam int MW   = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*SW-1:0] in_samples,
  input  logic [NCH*SW-1:0] pedestals,
  input  logic [NCH*SW-1:0] thresholds,
  input  logic [NCH-1:0]    coinc_mask,
  input  logic [MW-1:0]     min_mult,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH-1:0]    out_hits,
  output logic [OW-1:0]     out_sum,
  output logic              out_coinc
);
  localparam int STAGES = 4;

  logic              adv;
  logic [STAGES-1:0] vld_q;
  logic [NCH-1:0]    hit_s1;
  logic [NCH*SW-1:0] energy_s1;
  logic [NCH-1:0]    hit_s2;
  logic [NCH-1:0]    hit_s3;
  logic              coinc_s3;

  assign adv       = !vld_q[STAGES-1] || out_ready;
  assign in_ready  = adv;
  assign out_valid = vld_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld_q <= '0;
    else if (adv) vld_q <= {vld_q[STAGES-2:0], in_valid};
  end

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      hef_channel #(.SW(SW)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .sample    (in_samples[c*SW +: SW]),
        .pedestal  (pedestals[c*SW +: SW]),
        .threshold (thresholds[c*SW +: SW]),
        .hit_q     (hit_s1[c]),
        .energy_q  (energy_s1[c*SW +: SW])
      );
    end
  endgenerate

  hef_sum_tree #(.N(NCH), .IW(SW), .OW(OW), .GROUP(GROUP)) u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .terms (energy_s1),
    .sum_q (out_sum)
  );

  hef_coinc #(.N(NCH), .MW(MW)) u_coinc (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .hits     (hit_s1),
    .mask     (coinc_mask),
    .min_mult (min_mult),
    .flag_q   (coinc_s3)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_s2    <= '0;
      hit_s3    <= '0;
      out_hits  <= '0;
      out_coinc <= 1'b0;
    end else if (adv) begin
      hit_s2    <= hit_s1;
      hit_s3    <= hit_s2;
      out_hits  <= hit_s3;
      out_coinc <= coinc_s3;
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hits) && $stable(out_sum) && $stable(out_coinc))); // R7
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7
  AST_QUIET_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_hits == '0)) |-> (out_sum == '0)); // R3
  AST_COINC_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_coinc == ($countones(out_hits & coinc_mask) >= int'(min_mult)))); // R5
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
endmodule

// File: tb/hit_energy_frontend_test.sv
`timescale 1ns/1ps
module hit_energy_frontend_test;
  localparam int NCH = 16;
  localparam int SW  = 14;
  localparam int OW  = 16;
  localparam int MW  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [NCH*SW-1:0] in_samples;
  logic [NCH*SW-1:0] pedestals;
  logic [NCH*SW-1:0] thresholds;
  logic [NCH-1:0]    coinc_mask = '1;
  logic [MW-1:0]     min_mult = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [NCH-1:0]    out_hits;
  logic [OW-1:0]     out_sum;
  logic              out_coinc;

  int smp [NCH];
  int ped [NCH];
  int thr [NCH];

  typedef struct { int hits; int sum; int coinc; } exp_t;
  exp_t sb[$];

  int nchk = 0;
  int nerr = 0;
  logic [31:0] seed = 32'h1badf00d;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      in_samples[i*SW +: SW] = SW'(smp[i]);
      pedestals[i*SW +: SW]  = SW'(ped[i]);
      thresholds[i*SW +: SW] = SW'(thr[i]);
    end
  end

  hit_energy_frontend uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .pedestals(pedestals), .thresholds(thresholds),
    .coinc_mask(coinc_mask), .min_mult(min_mult), .out_valid(out_valid),
    .out_ready(out_ready), .out_hits(out_hits), .out_sum(out_sum), .out_coinc(out_coinc)
  );

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model();
    exp_t e;
    int v, cnt;
    e.hits = 0; e.sum = 0; cnt = 0;
    for (int i = 0; i < NCH; i++) begin
      v = (smp[i] > ped[i]) ? smp[i] - ped[i] : 0;
      if (v > thr[i]) begin
        e.hits |= (1 << i);
        e.sum  += v;
        if (coinc_mask[i]) cnt++;
      end
    end
    if (e.sum > 65535) e.sum = 65535;
    e.coinc = (cnt >= int'(min_mult)) ? 1 : 0;
    return e;
  endfunction

  task automatic set_cfg(int p, int tbase, int tstep, logic [NCH-1:0] m, int mm);
    for (int i = 0; i < NCH; i++) begin
      ped[i] = p;
      thr[i] = tbase + i * tstep;
    end
    coinc_mask = m;
    min_mult   = MW'(mm);
  endtask

  // kind 0: random, 1: full scale, 2: below pedestal, 3: at/just over threshold
  task automatic gen(int kind);
    for (int i = 0; i < NCH; i++) begin
      case (kind)
        0: smp[i] = int'(nxt() & 32'h3fff);
        1: smp[i] = 16383;
        2: smp[i] = int'(nxt() % 32'(ped[i]));
        default: smp[i] = ped[i] + thr[i] + (i % 2);
      endcase
    end
  endtask

  task automatic run_batch(int n, int kind, int stall, string stag, output int cycles);
    int sent;
    bit have;
    exp_t e;
    sent = 0; have = 0; cycles = 0;
    while (sent < n || sb.size() > 0 || have) begin
      @(negedge clk);
      cycles++;
      out_ready = (stall == 0) ? 1'b1 : ((nxt() % 100) >= 32'(stall));
      if (!have && sent < n) begin
        gen(kind);
        have = 1;
      end
      in_valid = have;
      #1;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          chk(0, "R7", "extra output word", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(int'(out_hits) == e.hits, "R2", "hit pattern", int'(out_hits), e.hits);
          chk(int'(out_sum) == e.sum, stag, "energy sum", int'(out_sum), e.sum);
          chk(int'(out_coinc) == e.coinc, "R5", "coincidence", int'(out_coinc), e.coinc);
        end
      end
      if (have && in_ready) begin
        sb.push_back(model());
        have = 0;
        sent++;
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int lat, s, cyc;
    set_cfg(0, 500, 0, '1, 16);
    for (int i = 0; i < NCH; i++) smp[i] = 0;

    // R8: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid idle", int'(out_valid), 0);

    // R6 latency, then R7 hold under stall
    for (int i = 0; i < NCH; i++) smp[i] = 1000;
    in_valid = 1'b1;
    out_ready = 1'b0;
    lat = 0;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (out_valid && lat == 0) lat = n;
      if (lat != 0) break;
    end
    chk(lat == 4, "R6", "latency in edges", lat, 4);
    chk(out_hits == 16'hffff, "R2", "all channels hit", int'(out_hits), 65535);
    chk(out_sum == 16'd16000, "R3", "sum of 16 x 1000", int'(out_sum), 16000);
    chk(out_coinc == 1'b1, "R5", "multiplicity 16", int'(out_coinc), 1);
    s = int'(out_sum);
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b1 && int'(out_sum) == s, "R7", "held word", int'(out_sum), s);
      chk(in_ready == 1'b0, "R7", "in_ready while stalled", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "word leaves once", int'(out_valid), 0);
    out_ready = 1'b0;

    // R3 and R6 throughput with no stalls
    set_cfg(1000, 4000, 300, '1, 8);
    run_batch(200, 0, 0, "R3", cyc);
    chk(cyc <= 206, "R6", "cycles for 200 words", cyc, 206);

    // R7 ordering under random back-pressure
    run_batch(200, 0, 40, "R3", cyc);

    // R2 boundary: equal to threshold is no hit
    run_batch(20, 3, 10, "R3", cyc);

    // R5 multiplicity and mask sweep
    for (int mm = 0; mm <= 17; mm++) begin
      for (int mk = 0; mk < 3; mk++) begin
        set_cfg(1000, 2000, 500, (mk == 0) ? 16'hffff : (mk == 1) ? 16'h00ff : 16'ha5a5, mm);
        run_batch(12, 0, 20, "R3", cyc);
      end
    end

    // R4 saturation
    set_cfg(0, 0, 0, '1, 16);
    run_batch(20, 1, 20, "R4", cyc);

    // R1 clamp at zero
    set_cfg(5000, 0, 0, '1, 1);
    run_batch(30, 2, 20, "R1", cyc);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule